// File: doc/BRIEF.md
# Pad Configuration and Pin Function Register Bank

This block is the configuration store for one 32-pin parallel I/O port. For every pin it keeps which of four peripheral functions the pin is muxed to, whether the pad pull-down is on, whether the input filter runs from the slow debounce clock or stays in glitch mode, whether the pin's output data register accepts direct writes, and whether the Schmitt trigger on the input buffer is active. A single 14-bit divider, shared by all pins of the port, sets the rate of the debounce clock.

Software reaches the block over a simple synchronous register bus: a byte address within the port's 0x200-byte window, a write strobe, write data and registered read data. Most pad controls use a triple of addresses. Writing 1s at the enable address sets bits, writing 1s at the disable address clears them, and a read-only status address shows the result. The two function-select registers, the divider and the Schmitt register are plain read/write words. The state drives per-pin vectors straight into the pad ring and the function multiplexers.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: After a synchronous reset, every readable register reads 0, `o_func_sel`, `o_pd_en`, `o_dbnc_sel`, `o_div` and `o_ow_en` are all 0 (function A, glitch mode, pull-down off), and `o_st_en` is all ones.
- R2: The words at 0x70 (select low) and 0x74 (select high) are plain read/write. Pin n's code sits at `o_func_sel[2n+1:2n]` as {high[n], low[n]}: 00 = A, 01 = B, 10 = C, 11 = D.
- R3: Writing 1s at 0x84 sets the matching debounce-select bits. Writing 1s at 0x80 clears them. 0x88 reads them back, and `o_dbnc_sel` shows them.
- R4: The divider at 0x8C keeps write-data bits [13:0] on `o_div` and discards higher bits. A read returns the value zero-extended.
- R5: Writing 1s at 0x94 sets pull-down bits and writing 1s at 0x90 clears them. 0x98 reads them back, and `o_pd_en` shows them.
- R6: Writing 1s at 0xA0 sets output-write-enable bits and writing 1s at 0xA4 clears them. 0xA8 reads them back, and `o_ow_en` shows them.
- R7: At any set or clear address, a 0 in the write data leaves that status bit unchanged.
- R8: The word at 0x100 is read/write. A 1 in bit n turns the Schmitt trigger off, so `o_st_en[n]` is the inverse of bit n.
- R9: Reads of the set/clear addresses, of unused offsets and of addresses whose bits [1:0] are not 00 return 0. Writes there change no state.
- R10: Status addresses 0x88, 0x98 and 0xA8 ignore writes. `i_rdata` is registered: it shows, one cycle after the address, the contents before any write made in that same cycle.
- R11: Every configuration output changes on the clock edge that takes the write, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_addr | input | 9 | Byte address within the port window |
| i_we | input | 1 | Write strobe |
| i_wdata | input | 32 | Write data |
| o_rdata | output | 32 | Registered read data |
| o_func_sel | output | 64 | 2-bit function code per pin |
| o_pd_en | output | 32 | Pull-down enable per pin |
| o_dbnc_sel | output | 32 | 1 = debounce clock, 0 = glitch filter |
| o_div | output | 14 | Debounce clock divider |
| o_st_en | output | 32 | Schmitt trigger enable per pin |
| o_ow_en | output | 32 | Direct output write enable per pin |

## Verification
On every cycle the assertions check that a set or clear write reaches exactly the addressed status bits on the next edge, and that a cycle without such a write leaves the status unchanged. They also check that writes to status addresses do nothing, that the Schmitt output follows the inverse of the written word, and that divider and unmapped reads come back with zeros where no state exists. Only the bench scenarios can show the full address map: the 2-bit function encoding across the two select words, read-before-write ordering within a cycle, the effect of misaligned addresses, and the fact that the outputs stay put until the write edge.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int OFF_SEL_LO  = 'h070;
  localparam int OFF_SEL_HI  = 'h074;
  localparam int OFF_FLT_CLR = 'h080;
  localparam int OFF_FLT_SET = 'h084;
  localparam int OFF_FLT_STS = 'h088;
  localparam int OFF_DIV     = 'h08C;
  localparam int OFF_PD_CLR  = 'h090;
  localparam int OFF_PD_SET  = 'h094;
  localparam int OFF_PD_STS  = 'h098;
  localparam int OFF_OW_SET  = 'h0A0;
  localparam int OFF_OW_CLR  = 'h0A4;
  localparam int OFF_OW_STS  = 'h0A8;
  localparam int OFF_SCHMITT = 'h100;

  typedef enum logic [1:0] {
    FN_A = 2'b00,
    FN_B = 2'b01,
    FN_C = 2'b10,
    FN_D = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/padcfg_w1sc.sv
module padcfg_w1sc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat
);
  logic [W-1:0] set_m, clr_m;

  always_comb begin
    set_m = set_we ? wdata : '0;
    clr_m = clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat | set_m) & ~clr_m;
  end

  // R3/R5/R6: written ones land in status on the next edge
  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((stat & $past(wdata)) == $past(wdata)));
  a_r3_clr_lands: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat & $past(wdata)) == '0));
  // R7: zero bits of the write data leave status bits alone
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> ((stat & ~$past(wdata)) == ($past(stat) & ~$past(wdata))));
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(stat));
endmodule

// File: rtl/padcfg_rwreg.sv
module padcfg_rwreg #(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata[W-1:0];
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/padcfg_fsel.sv
module padcfg_fsel
  import padcfg_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic [PINS-1:0]   sel_lo,
  input  logic [PINS-1:0]   sel_hi,
  output logic [2*PINS-1:0] func_sel
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    pin_fn_e fn;
    assign fn = pin_fn_e'({sel_hi[n], sel_lo[n]});
    assign func_sel[2*n +: 2] = fn;
  end
endmodule

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank
  import padcfg_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DW     = 32,
  parameter int DIV_W  = 14,
  parameter int WINDOW = 'h200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(WINDOW)-1:0]  i_addr,
  input  logic                       i_we,
  input  logic [DW-1:0]              i_wdata,
  output logic [DW-1:0]              o_rdata,
  output logic [2*PINS-1:0]          o_func_sel,
  output logic [PINS-1:0]            o_pd_en,
  output logic [PINS-1:0]            o_dbnc_sel,
  output logic [DIV_W-1:0]           o_div,
  output logic [PINS-1:0]            o_st_en,
  output logic [PINS-1:0]            o_ow_en
);
  localparam int AW = $clog2(WINDOW);

  logic hit_sel_lo, hit_sel_hi, hit_div, hit_sch;
  logic hit_flt_set, hit_flt_clr, hit_flt_sts;
  logic hit_pd_set, hit_pd_clr, hit_pd_sts;
  logic hit_ow_set, hit_ow_clr, hit_ow_sts;
  logic readable;

  always_comb begin
    hit_sel_lo  = (i_addr == AW'(OFF_SEL_LO));
    hit_sel_hi  = (i_addr == AW'(OFF_SEL_HI));
    hit_div     = (i_addr == AW'(OFF_DIV));
    hit_sch     = (i_addr == AW'(OFF_SCHMITT));
    hit_flt_set = (i_addr == AW'(OFF_FLT_SET));
    hit_flt_clr = (i_addr == AW'(OFF_FLT_CLR));
    hit_flt_sts = (i_addr == AW'(OFF_FLT_STS));
    hit_pd_set  = (i_addr == AW'(OFF_PD_SET));
    hit_pd_clr  = (i_addr == AW'(OFF_PD_CLR));
    hit_pd_sts  = (i_addr == AW'(OFF_PD_STS));
    hit_ow_set  = (i_addr == AW'(OFF_OW_SET));
    hit_ow_clr  = (i_addr == AW'(OFF_OW_CLR));
    hit_ow_sts  = (i_addr == AW'(OFF_OW_STS));
    readable    = hit_sel_lo | hit_sel_hi | hit_div | hit_sch |
                  hit_flt_sts | hit_pd_sts | hit_ow_sts;
  end

  logic [PINS-1:0]  sel_lo_q, sel_hi_q, sch_q, flt_q, pd_q, ow_q;
  logic [DIV_W-1:0] div_q;

  padcfg_rwreg #(.W(PINS),  .DW(DW)) u_sel_lo (.clk(clk), .rst(rst), .we(i_we & hit_sel_lo), .wdata(i_wdata), .q(sel_lo_q));
  padcfg_rwreg #(.W(PINS),  .DW(DW)) u_sel_hi (.clk(clk), .rst(rst), .we(i_we & hit_sel_hi), .wdata(i_wdata), .q(sel_hi_q));
  padcfg_rwreg #(.W(DIV_W), .DW(DW)) u_div    (.clk(clk), .rst(rst), .we(i_we & hit_div),    .wdata(i_wdata), .q(div_q));
  padcfg_rwreg #(.W(PINS),  .DW(DW)) u_sch    (.clk(clk), .rst(rst), .we(i_we & hit_sch),    .wdata(i_wdata), .q(sch_q));

  padcfg_w1sc #(.W(PINS)) u_flt (.clk(clk), .rst(rst), .set_we(i_we & hit_flt_set),
    .clr_we(i_we & hit_flt_clr), .wdata(i_wdata[PINS-1:0]), .stat(flt_q));
  padcfg_w1sc #(.W(PINS)) u_pd  (.clk(clk), .rst(rst), .set_we(i_we & hit_pd_set),
    .clr_we(i_we & hit_pd_clr), .wdata(i_wdata[PINS-1:0]), .stat(pd_q));
  padcfg_w1sc #(.W(PINS)) u_ow  (.clk(clk), .rst(rst), .set_we(i_we & hit_ow_set),
    .clr_we(i_we & hit_ow_clr), .wdata(i_wdata[PINS-1:0]), .stat(ow_q));

  padcfg_fsel #(.PINS(PINS)) u_fsel (.sel_lo(sel_lo_q), .sel_hi(sel_hi_q), .func_sel(o_func_sel));

  assign o_pd_en    = pd_q;
  assign o_dbnc_sel = flt_q;
  assign o_div      = div_q;
  assign o_st_en    = ~sch_q;
  assign o_ow_en    = ow_q;

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if      (hit_sel_lo)  rd_next = DW'(sel_lo_q);
    else if (hit_sel_hi)  rd_next = DW'(sel_hi_q);
    else if (hit_div)     rd_next = DW'(div_q);
    else if (hit_sch)     rd_next = DW'(sch_q);
    else if (hit_flt_sts) rd_next = DW'(flt_q);
    else if (hit_pd_sts)  rd_next = DW'(pd_q);
    else if (hit_ow_sts)  rd_next = DW'(ow_q);
  end

  always_ff @(posedge clk) begin
    if (rst) o_rdata <= '0;
    else     o_rdata <= rd_next;
  end

  // R9: unmapped or write-only addresses read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !readable |=> (o_rdata == '0));
  // R4: no bits above the divider width ever come back
  a_r4_div_upper_zero: assert property (@(posedge clk) disable iff (rst)
    hit_div |=> (o_rdata[DW-1:DIV_W] == '0));
  // R8: Schmitt enable is the inverse of the written word
  a_r8_schmitt_inv: assert property (@(posedge clk) disable iff (rst)
    (i_we && hit_sch) |=> (o_st_en == ~$past(i_wdata[PINS-1:0])));
  // R10: status addresses ignore writes
  a_r10_sts_ro: assert property (@(posedge clk) disable iff (rst)
    (i_we && (hit_flt_sts || hit_pd_sts || hit_ow_sts)) |=>
      ($stable(o_dbnc_sel) && $stable(o_pd_en) && $stable(o_ow_en)));
endmodule

// File: tb/tb_gpio_padcfg_bank.sv
module tb_gpio_padcfg_bank;
  logic        clk = 0;
  logic        rst = 1;
  logic [8:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] func_sel;
  logic [31:0] pd_en, dbnc_sel, st_en, ow_en;
  logic [13:0] div;

  always #5 clk = ~clk;

  gpio_padcfg_bank dut (
    .clk(clk), .rst(rst), .i_addr(addr), .i_we(we), .i_wdata(wdata),
    .o_rdata(rdata), .o_func_sel(func_sel), .o_pd_en(pd_en),
    .o_dbnc_sel(dbnc_sel), .o_div(div), .o_st_en(st_en), .o_ow_en(ow_en));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; logic [8:0] a; } rd_item_t;
  rd_item_t q[$];
  logic rd_v = 0, rd_cap = 0;

  // reference model, from the requirements
  logic [31:0] m_lo = 0, m_hi = 0, m_flt = 0, m_pd = 0, m_ow = 0, m_sch = 0;
  logic [13:0] m_div = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_fsel();
    logic [63:0] r;
    for (int n = 0; n < 32; n++) r[2*n +: 2] = {m_hi[n], m_lo[n]};
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [8:0] a);
    case (a)
      9'h070: return m_lo;
      9'h074: return m_hi;
      9'h088: return m_flt;
      9'h08C: return {18'd0, m_div};
      9'h098: return m_pd;
      9'h0A8: return m_ow;
      9'h100: return m_sch;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(logic [8:0] a, logic [31:0] d);
    case (a)
      9'h070: m_lo = d;
      9'h074: m_hi = d;
      9'h084: m_flt = m_flt | d;
      9'h080: m_flt = m_flt & ~d;
      9'h08C: m_div = d[13:0];
      9'h094: m_pd = m_pd | d;
      9'h090: m_pd = m_pd & ~d;
      9'h0A0: m_ow = m_ow | d;
      9'h0A4: m_ow = m_ow & ~d;
      9'h100: m_sch = d;
      default: ;
    endcase
  endtask

  // driver: one bus cycle; a read pushes the model's pre-write value
  task automatic bus(logic [8:0] a, logic w, logic [31:0] d, logic rd, string tag);
    @(negedge clk);
    addr = a; we = w; wdata = d; rd_v = rd;
    if (rd) q.push_back('{model_read(a), tag, a});
    if (w) model_write(a, d);
  endtask

  task automatic idle();
    @(negedge clk);
    we = 0; rd_v = 0;
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d); bus(a, 1, d, 0, "");  idle(); endtask
  task automatic rd(logic [8:0] a, string tag);     bus(a, 0, 0, 1, tag); idle(); endtask

  task automatic check_outs(string tag);
    check({tag, " fsel"}, func_sel, exp_fsel());
    check({tag, " pd"},   {32'd0, pd_en},    {32'd0, m_pd});
    check({tag, " dbnc"}, {32'd0, dbnc_sel}, {32'd0, m_flt});
    check({tag, " div"},  {50'd0, div},      {50'd0, m_div});
    check({tag, " st"},   {32'd0, st_en},    {32'd0, ~m_sch});
    check({tag, " ow"},   {32'd0, ow_en},    {32'd0, m_ow});
  endtask

  // monitor: compares read data one cycle after the address
  always @(posedge clk) rd_cap <= rd_v;
  always @(negedge clk) begin
    if (rd_cap && q.size() > 0) begin
      rd_item_t it;
      it = q.pop_front();
      check({it.tag, " read"}, {32'd0, rdata}, {32'd0, it.exp});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    check("R1 st_all_on", {32'd0, st_en}, {32'd0, 32'hFFFF_FFFF});
    rd(9'h070, "R1"); rd(9'h088, "R1"); rd(9'h100, "R1");

    // R2 function selection, several patterns
    wr(9'h070, 32'hA5A5_0F0F);
    wr(9'h074, 32'h3C3C_00FF);
    check_outs("R2");
    check("R2 pin0_D", {62'd0, func_sel[1:0]}, {62'd0, 2'b11});
    check("R2 pin4_C", {62'd0, func_sel[9:8]}, {62'd0, 2'b10});
    rd(9'h070, "R2"); rd(9'h074, "R2");
    wr(9'h074, 32'h0000_0000);
    check_outs("R2 hi_cleared");

    // R3 filter clock select, R7 zero bits hold
    wr(9'h084, 32'h0000_00F0);
    check_outs("R3 set");
    wr(9'h084, 32'h8000_0000);
    wr(9'h080, 32'h0000_0030);
    check_outs("R3 clr");
    wr(9'h084, 32'h0);
    wr(9'h080, 32'h0);
    check_outs("R7 zero_write");
    rd(9'h088, "R3");

    // R4 divider truncation
    wr(9'h08C, 32'hFFFF_ABCD);
    check("R4 div", {50'd0, div}, {50'd0, 14'h2BCD});
    rd(9'h08C, "R4");

    // R5 pull-down, R6 output write enable
    wr(9'h094, 32'h1234_5678);
    wr(9'h090, 32'h0000_0078);
    check_outs("R5");
    rd(9'h098, "R5");
    wr(9'h0A0, 32'hFFFF_0000);
    wr(9'h0A4, 32'h0F0F_0000);
    check_outs("R6");
    rd(9'h0A8, "R6");

    // R8 Schmitt polarity
    wr(9'h100, 32'h8000_0001);
    check("R8 st", {32'd0, st_en}, {32'd0, 32'h7FFF_FFFE});
    rd(9'h100, "R8");

    // R9 write-only, reserved and misaligned
    rd(9'h084, "R9"); rd(9'h080, "R9"); rd(9'h094, "R9"); rd(9'h0A0, "R9");
    rd(9'h00C, "R9"); rd(9'h072, "R9"); rd(9'h1FC, "R9");
    wr(9'h1F0, 32'hFFFF_FFFF);
    wr(9'h072, 32'hFFFF_FFFF);
    wr(9'h086, 32'hFFFF_FFFF);
    check_outs("R9 no_effect");

    // R10 status read-only, read-before-write
    wr(9'h088, 32'hFFFF_FFFF);
    wr(9'h098, 32'h0);
    wr(9'h0A8, 32'hFFFF_FFFF);
    check_outs("R10 sts_ro");
    rd(9'h088, "R10");
    bus(9'h070, 1, 32'h1111_2222, 1, "R10 old_value");
    idle();
    rd(9'h070, "R10 new_value");

    // R11 outputs wait for the write edge
    @(negedge clk);
    addr = 9'h094; wdata = 32'hFFFF_FFFF; we = 1;
    #2 check("R11 before_edge", {32'd0, pd_en}, {32'd0, m_pd});
    model_write(9'h094, 32'hFFFF_FFFF);
    @(negedge clk);
    we = 0;
    check("R11 after_edge", {32'd0, pd_en}, {32'd0, 32'hFFFF_FFFF});

    repeat (3) @(negedge clk);
    check("queue_drained", {32'd0, q.size()}, 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule